// File: doc/BRIEF.md
# Sampled PID Loop Controller with Soft-Start Ramp Override

This block closes a digital power-supply control loop. On every cycle where the sample strobe is high it forms the error between a signed setpoint and a signed measurement and combines three terms: a proportional term on the error, an integral term that accumulates the current and previous errors into a clamped accumulator, and a derivative term taken on the measurement rather than on the error. The sum is rescaled by a fixed number of fraction bits and clamped into an unsigned 16-bit output. The output is registered and comes with a valid flag one cycle after the strobe.

A supervisor can take the loop out of control. If the collapse flag is high, or a parameter-change pulse arrives, the controller enters an override mode. In this mode it stops using the loop sum and raises the output from its present value by a programmed step on each sample. The steps are sized to keep the inrush below the supply rating. Once the ramp reaches full scale, the override ends and the next sample is again under loop control. While the override is active the integrator is frozen. The stored previous error and previous measurement still track every sample, so the loop returns without a kick.

Top module: `pid_ramp_ctrl`

## Requirements
- R1: While rst_ni is low, out_o and out_vld_o are 0. The integral accumulator, previous error, previous measurement and override state all return to 0 or inactive.
- R2: out_vld_o equals sample_vld_i delayed by one clock. out_o changes only on the edge that follows a cycle with sample_vld_i high.
- R3: The error is setpoint_i minus meas_i, formed as a 17-bit signed value. The proportional term is kp_i times the error.
- R4: On each loop-mode sample, the integral accumulator adds ki_i times the sum of the current error and the error stored at the previous sample (0 after reset).
- R5: After each update the accumulator is clamped into [int_lo_i, int_hi_i]: any value above int_hi_i becomes int_hi_i, and any value below int_lo_i becomes int_lo_i.
- R6: The derivative term is kd_i times the difference meas_i minus the measurement stored at the previous sample (0 after reset).
- R7: In loop mode the output is (P + updated accumulator + D) shifted arithmetically right by FRAC_W (default 8). The result is clamped to the range 0 to 65535.
- R8: The override is active in a cycle if it was already active, or if collapse_i or param_chg_i is high in that cycle. A sample in an active cycle sets out_o to min(out_o + ramp_step_i, 65535).
- R9: During override samples the integral accumulator holds its value. The previous-error and previous-measurement registers still update.
- R10: An override sample that produces 65535 ends the override. When collapse_i and param_chg_i are low, the next sample is computed in loop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_vld_i | input | 1 | New sample strobe |
| setpoint_i | input | 16 | Signed setpoint |
| meas_i | input | 16 | Signed measured process value |
| kp_i | input | 16 | Signed proportional gain, FRAC_W fraction bits |
| ki_i | input | 16 | Signed integral gain |
| kd_i | input | 16 | Signed derivative gain |
| int_hi_i | input | 40 | Signed upper accumulator limit |
| int_lo_i | input | 40 | Signed lower accumulator limit |
| ramp_step_i | input | 16 | Unsigned ramp increment per sample |
| collapse_i | input | 1 | Output-near-collapse flag |
| param_chg_i | input | 1 | Parameter-change pulse |
| out_o | output | 16 | Unsigned saturated control output |
| out_vld_o | output | 1 | Output valid, one cycle after the strobe |

## Verification
The loop is driven in four ways. A constant error with only the proportional gain active isolates P and checks both output clamps. A held error with only the integral gain active separates the two-error integration from single-error integration, and it runs until both accumulator limits are reached. A measurement staircase with only the derivative gain active shows that the difference is taken on the measurement. Override runs start from a non-sample parameter pulse and from a collapse flag that rises together with a sample. The integral gain stays active during these runs, so the frozen accumulator and the tracked previous values can be seen when control returns to the loop. A reset in the middle of the run confirms that the stored measurement is cleared.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic {
    MODE_PID  = 1'b0,
    MODE_RAMP = 1'b1
  } ctl_mode_e;
endpackage

// File: rtl/pid_terms.sv
module pid_terms #(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic signed [DW-1:0]    sp_i,
  input  logic signed [DW-1:0]    meas_i,
  input  logic signed [DW-1:0]    meas_prev_i,
  input  logic signed [DW:0]      err_prev_i,
  input  logic signed [DW-1:0]    kp_i,
  input  logic signed [DW-1:0]    ki_i,
  input  logic signed [DW-1:0]    kd_i,
  output logic signed [DW:0]      err_o,
  output logic signed [ACC_W-1:0] p_o,
  output logic signed [ACC_W-1:0] i_inc_o,
  output logic signed [ACC_W-1:0] d_o
);
  localparam int unsigned EW = DW + 1;

  logic signed [EW-1:0]    dm;
  logic signed [ACC_W-1:0] kp_x, ki_x, kd_x, err_x, eprev_x, dm_x;

  assign err_o = $signed({sp_i[DW-1], sp_i}) - $signed({meas_i[DW-1], meas_i});
  assign dm    = $signed({meas_i[DW-1], meas_i}) - $signed({meas_prev_i[DW-1], meas_prev_i});

  assign kp_x    = $signed({{(ACC_W-DW){kp_i[DW-1]}}, kp_i});
  assign ki_x    = $signed({{(ACC_W-DW){ki_i[DW-1]}}, ki_i});
  assign kd_x    = $signed({{(ACC_W-DW){kd_i[DW-1]}}, kd_i});
  assign err_x   = $signed({{(ACC_W-EW){err_o[EW-1]}}, err_o});
  assign eprev_x = $signed({{(ACC_W-EW){err_prev_i[EW-1]}}, err_prev_i});
  assign dm_x    = $signed({{(ACC_W-EW){dm[EW-1]}}, dm});

  assign p_o     = kp_x * err_x;
  assign i_inc_o = ki_x * (err_x + eprev_x);
  assign d_o     = kd_x * dm_x;
endmodule

// File: rtl/pid_integ.sv
module pid_integ #(
  parameter int unsigned ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [ACC_W-1:0] inc_i,
  input  logic signed [ACC_W-1:0] hi_i,
  input  logic signed [ACC_W-1:0] lo_i,
  output logic signed [ACC_W-1:0] integ_nxt_o
);
  localparam int unsigned SW = ACC_W + 1;

  logic signed [ACC_W-1:0] integ_q;
  logic signed [SW-1:0]    sum, hi_x, lo_x;

  assign sum  = $signed({integ_q[ACC_W-1], integ_q}) + $signed({inc_i[ACC_W-1], inc_i});
  assign hi_x = $signed({hi_i[ACC_W-1], hi_i});
  assign lo_x = $signed({lo_i[ACC_W-1], lo_i});

  always_comb begin
    if (sum > hi_x)      integ_nxt_o = hi_i;
    else if (sum < lo_x) integ_nxt_o = lo_i;
    else                 integ_nxt_o = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    integ_q <= '0;
    else if (upd_i) integ_q <= integ_nxt_o;
  end

  p_integ_lim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && lo_i <= hi_i) |=> (integ_q <= $past(hi_i) && integ_q >= $past(lo_i)));

  p_integ_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(integ_q));
endmodule

// File: rtl/ramp_ovr.sv
module ramp_ovr
  import pid_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic          req_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] step_i,
  output logic [DW-1:0] ramp_o,
  output logic          active_o
);
  localparam logic [DW-1:0] FULL = '1;

  ctl_mode_e    state_q, state_d;
  logic [DW:0]  add;

  assign add      = {1'b0, cur_i} + {1'b0, step_i};
  assign ramp_o   = add[DW] ? FULL : add[DW-1:0];
  assign active_o = (state_q == MODE_RAMP) || req_i;
  assign state_d  = (active_o && !(sample_i && ramp_o == FULL)) ? MODE_RAMP : MODE_PID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MODE_PID;
    else         state_q <= state_d;
  end

  p_ramp_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sample_i) |=> state_q == MODE_RAMP);

  p_ramp_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && active_o && ramp_o == FULL) |=> state_q == MODE_PID);
endmodule

// File: rtl/pid_ramp_ctrl.sv
module pid_ramp_ctrl #(
  parameter int unsigned DW     = 16,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_vld_i,
  input  logic signed [DW-1:0]    setpoint_i,
  input  logic signed [DW-1:0]    meas_i,
  input  logic signed [DW-1:0]    kp_i,
  input  logic signed [DW-1:0]    ki_i,
  input  logic signed [DW-1:0]    kd_i,
  input  logic signed [ACC_W-1:0] int_hi_i,
  input  logic signed [ACC_W-1:0] int_lo_i,
  input  logic [DW-1:0]           ramp_step_i,
  input  logic                    collapse_i,
  input  logic                    param_chg_i,
  output logic [DW-1:0]           out_o,
  output logic                    out_vld_o
);
  localparam int unsigned SW   = ACC_W + 2;
  localparam logic [DW-1:0] FULL = '1;

  logic signed [DW:0]      err, err_prev_q;
  logic signed [DW-1:0]    meas_prev_q;
  logic signed [ACC_W-1:0] p_term, i_inc, d_term, integ_nxt;
  logic signed [SW-1:0]    pid_sum, pid_sh;
  logic [DW-1:0]           pid_out, ramp_val, out_q;
  logic                    ovr_active, vld_q;

  pid_terms #(.DW(DW), .ACC_W(ACC_W)) i_terms (
    .sp_i       (setpoint_i),
    .meas_i     (meas_i),
    .meas_prev_i(meas_prev_q),
    .err_prev_i (err_prev_q),
    .kp_i       (kp_i),
    .ki_i       (ki_i),
    .kd_i       (kd_i),
    .err_o      (err),
    .p_o        (p_term),
    .i_inc_o    (i_inc),
    .d_o        (d_term)
  );

  pid_integ #(.ACC_W(ACC_W)) i_integ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (sample_vld_i && !ovr_active),
    .inc_i      (i_inc),
    .hi_i       (int_hi_i),
    .lo_i       (int_lo_i),
    .integ_nxt_o(integ_nxt)
  );

  ramp_ovr #(.DW(DW)) i_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_vld_i),
    .req_i   (collapse_i || param_chg_i),
    .cur_i   (out_q),
    .step_i  (ramp_step_i),
    .ramp_o  (ramp_val),
    .active_o(ovr_active)
  );

  assign pid_sum = $signed({{2{p_term[ACC_W-1]}}, p_term})
                 + $signed({{2{integ_nxt[ACC_W-1]}}, integ_nxt})
                 + $signed({{2{d_term[ACC_W-1]}}, d_term});
  assign pid_sh  = pid_sum >>> FRAC_W;

  always_comb begin
    if (pid_sh[SW-1])          pid_out = '0;
    else if (|pid_sh[SW-2:DW]) pid_out = FULL;
    else                       pid_out = pid_sh[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q       <= '0;
      vld_q       <= 1'b0;
      err_prev_q  <= '0;
      meas_prev_q <= '0;
    end else begin
      vld_q <= sample_vld_i;
      if (sample_vld_i) begin
        out_q       <= ovr_active ? ramp_val : pid_out;
        err_prev_q  <= err;
        meas_prev_q <= meas_i;
      end
    end
  end

  assign out_o     = out_q;
  assign out_vld_o = vld_q;

  p_vld_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |=> out_vld_o);

  p_vld_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> !out_vld_o);

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable(out_o));

  p_ramp_mono_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && ovr_active) |=> out_o >= $past(out_o));
endmodule

// File: tb/test_pid_ramp_ctrl.sv
module test_pid_ramp_ctrl;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               sample = 1'b0;
  logic signed [15:0] sp = '0, meas = '0, kp = '0, ki = '0, kd = '0;
  logic signed [39:0] ihi = 40'sd1000000000, ilo = -40'sd1000000000;
  logic [15:0]        step = '0;
  logic               collapse = 1'b0, pchg = 1'b0;
  logic [15:0]        out;
  logic               vld;

  int checks = 0, errors = 0;
  bit done = 0;

  longint m_integ, m_eprev, m_mprev, m_out;
  bit     m_ovr;

  always #2.5 clk = ~clk;

  pid_ramp_ctrl i_pid_ramp_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(sample),
    .setpoint_i(sp), .meas_i(meas), .kp_i(kp), .ki_i(ki), .kd_i(kd),
    .int_hi_i(ihi), .int_lo_i(ilo), .ramp_step_i(step),
    .collapse_i(collapse), .param_chg_i(pchg),
    .out_o(out), .out_vld_o(vld)
  );

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_integ = 0; m_eprev = 0; m_mprev = 0; m_out = 0; m_ovr = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sample = 1'b0; collapse = 1'b0; pchg = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(out, 0, "R1 out");
    chk(vld, 0, "R1 vld");
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one clock: drive at negedge, predict, check at following negedge
  task automatic cyc(input bit smp, input bit col, input bit chg, input string tag);
    longint err, r, s, nout;
    bit     mode, novr;
    sample = smp; collapse = col; pchg = chg;
    mode = m_ovr || col || chg;
    nout = m_out;
    novr = mode;
    if (smp) begin
      err = longint'(sp) - longint'(meas);
      if (mode) begin
        r = m_out + longint'(step);
        if (r > 65535) r = 65535;
        nout = r;
        novr = (r != 65535);
      end else begin
        m_integ = m_integ + longint'(ki) * (err + m_eprev);
        if (m_integ > longint'(ihi)) m_integ = longint'(ihi);
        if (m_integ < longint'(ilo)) m_integ = longint'(ilo);
        s = longint'(kp) * err + m_integ + longint'(kd) * (longint'(meas) - m_mprev);
        s = s >>> 8;
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        nout = s;
        novr = 1'b0;
      end
      m_eprev = err;
      m_mprev = longint'(meas);
    end
    m_out = nout;
    m_ovr = novr;
    @(posedge clk);
    @(negedge clk);
    chk(longint'(out), m_out, tag);
    chk(longint'(vld), longint'(smp), "R2 vld");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R3 proportional, R7 clamps
    kp = 16'sd256;
    sp = 16'sd1000; meas = 16'sd200; cyc(1, 0, 0, "R3 p");
    cyc(0, 0, 0, "R2 hold");
    cyc(0, 0, 0, "R2 hold");
    sp = 16'sd300;  meas = 16'sd100; cyc(1, 0, 0, "R3 p");
    sp = -16'sd500; meas = 16'sd500; cyc(1, 0, 0, "R7 low clamp");
    kp = 16'sd32767; sp = 16'sd32767; meas = -16'sd32768; cyc(1, 0, 0, "R7 high clamp");
    sp = 16'sd0; meas = 16'sd0; cyc(1, 0, 0, "R3 zero");

    // R4 two-error integration, R5 limits
    kp = 16'sd0; ki = 16'sd64; ihi = 40'sd200000; ilo = -40'sd30000;
    sp = 16'sd100; meas = 16'sd0;
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R4 integ");
    sp = 16'sd1000;
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R5 hi limit");
    kp = 16'sd256; sp = 16'sd0; meas = -16'sd200;
    cyc(1, 0, 0, "R5 held at hi");
    sp = -16'sd1000; meas = 16'sd0;
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R5 lo limit");
    sp = 16'sd0; meas = -16'sd300;
    cyc(1, 0, 0, "R5 lo visible");

    // R6 derivative on measurement
    kp = 16'sd0; ki = 16'sd0; kd = 16'sd512; sp = 16'sd0;
    meas = 16'sd0;   cyc(1, 0, 0, "R6 d");
    meas = 16'sd100; cyc(1, 0, 0, "R6 d");
    meas = 16'sd300; cyc(1, 0, 0, "R6 d");
    sp = 16'sd5000;  cyc(1, 0, 0, "R6 no setpoint kick");
    kd = -16'sd512; meas = 16'sd250; cyc(1, 0, 0, "R6 d");

    // R8/R9/R10 override from a non-sample pulse
    kd = 16'sd0; kp = 16'sd256; ki = 16'sd8; ihi = 40'sd1000000000; ilo = -40'sd1000000000;
    sp = 16'sd2000; meas = 16'sd0;
    cyc(1, 0, 0, "R3 pre-ovr");
    step = 16'd10000;
    cyc(0, 0, 1, "R8 pulse no sample");
    cyc(0, 0, 0, "R8 wait");
    for (int i = 0; i < 8; i++) begin
      sp = 16'(16'sd2000 + 16'(i * 100));
      meas = 16'(i * 10);
      cyc(1, 0, 0, "R8 ramp");
    end
    cyc(1, 0, 0, "R10 back to pid");
    cyc(1, 0, 0, "R9 bumpless");

    // collapse rising with a sample, held, then released
    step = 16'd20000;
    cyc(1, 1, 0, "R8 collapse");
    cyc(1, 1, 0, "R8 collapse");
    cyc(1, 1, 0, "R8 collapse");
    cyc(1, 1, 0, "R8 collapse at full");
    cyc(1, 0, 0, "R10 exit");
    cyc(1, 0, 0, "R10 pid");
    step = 16'd0;
    cyc(0, 0, 1, "R8 zero step");
    cyc(1, 0, 0, "R8 zero step hold");
    step = 16'd65535;
    cyc(1, 0, 0, "R10 exit big step");
    cyc(1, 0, 0, "R10 pid");

    // R1 mid-run reset clears stored measurement
    do_reset();
    kp = 16'sd0; ki = 16'sd0; kd = 16'sd256; sp = 16'sd0; meas = 16'sd100;
    cyc(1, 0, 0, "R1 meas cleared");
    cyc(1, 0, 0, "R6 d zero");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule